// File: doc/BRIEF.md
# Priority Round-Robin DMA Channel Arbiter

This block decides which of eight DMA channels may run its next transfer. Each channel has three settings: an enable bit, a request mode and a two-bit priority level. The request mode is either memory-to-memory or peripheral-linked. A memory-to-memory channel requests for as long as it is enabled. A peripheral-linked channel requests only while its peripheral's DMA request line is high.

On a cycle with no grant outstanding, the arbiter picks one requester. The highest priority level wins. Among channels at that level, the choice rotates round-robin, and each level has its own rotation pointer. The winner is registered as a one-hot grant together with a grant-valid flag. The grant stays fixed while the transfer engine performs its read burst and then its write burst. A channel that starts to request at a higher level in the meantime does not take the grant away. The engine ends the grant with a done pulse after both bursts, or with an abort pulse on an error. The arbiter then arbitrates again.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A channel whose mode bit is 0 (memory-to-memory) requests whenever its enable bit is 1, whatever its peripheral request line shows.
- R2: A channel whose mode bit is 1 (peripheral-linked) requests only while its enable bit is 1 and its peripheral request line is high.
- R3: A channel whose enable bit is 0 never requests and is never granted.
- R4: Priority is the 2-bit field at bits [2c+1:2c] of `ch_prio` for channel c, and 3 is the highest level. When requests exist at several levels, a channel at the highest requesting level is granted.
- R5: Among requesters at the same level, the winner is the first requesting channel at or above that level's pointer, counting upward with wrap-around. The pointer moves to the channel just past the winner only when a grant at that level is issued. All pointers are 0 after reset.
- R6: If `grant_valid` is low and at least one channel requests at a clock edge, then from that edge onward `grant_valid` is high and `grant` is one-hot, with its set bit on a channel that was requesting.
- R7: While `grant_valid` is high and neither `burst_done` nor `burst_abort` is high, `grant` and `grant_valid` keep their values at the next edge, whatever the requests do.
- R8: While `grant_valid` is high, a `burst_done` or `burst_abort` at an edge clears `grant_valid` and `grant` at that edge. Arbitration happens again at the following edge.
- R9: After reset, `grant` is all zero and `grant_valid` is low. Whenever `grant_valid` is low, `grant` is zero.
- R10: `burst_done` and `burst_abort` have no effect while `grant_valid` is low, and with no request pending `grant_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | 8 | Per-channel enable bit |
| ch_mode | input | 8 | Per-channel request mode: 0 memory-to-memory, 1 peripheral-linked |
| ch_prio | input | 16 | Per-channel 2-bit priority, channel c at bits [2c+1:2c] |
| periph_req | input | 8 | Per-channel peripheral DMA request line |
| burst_done | input | 1 | Pulse from the engine: read and write bursts complete |
| burst_abort | input | 1 | Pulse from the engine: transfer ended by an error |
| grant | output | 8 | One-hot registered grant |
| grant_valid | output | 1 | A grant is outstanding |

## Verification
Directed cases set up one request at a time. They separate a memory-to-memory request from a peripheral-linked one, a disabled channel from an enabled one, and a low level from a higher one. A three-channel group at one level shows that the rotation follows the order 0, 4, 7 and then wraps. A hold case raises a level-3 request while a level-0 channel is granted; a preemptive arbiter would switch to the new channel, and this one must not. The random phase changes configurations, peripheral lines and done/abort pulses, and also sends pulses when no grant is outstanding. A bench model with its own per-level pointers computes the expected grant on every cycle. This catches a pointer that is shared between levels, or one that advances when it should not.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    XFER_MEM2MEM = 1'b0,
    XFER_PERIPH  = 1'b1
  } xfer_mode_e;

endpackage

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] ch_mode,
  input  logic [NUM_CH-1:0] periph_req,
  output logic [NUM_CH-1:0] req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    xfer_mode_e mode_c;
    assign mode_c = xfer_mode_e'(ch_mode[c]);
    // R1 / R2 / R3: enable gates every request source
    assign req[c] = ch_enable[c] & ((mode_c == XFER_MEM2MEM) | periph_req[c]);
  end

endmodule

// File: rtl/dma_level_rr.sv
module dma_level_rr #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              adv,
  output logic              any_req,
  output logic [NUM_CH-1:0] pick_oh
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic [IDX_W-1:0] pick_idx;

  // search upward from the pointer, wrapping
  always_comb begin
    logic found;
    found    = 1'b0;
    pick_oh  = '0;
    pick_idx = ptr_q;
    for (int off = 0; off < NUM_CH; off++) begin
      int idx;
      idx = (int'(ptr_q) + off) % NUM_CH;
      if (!found && req[idx]) begin
        found         = 1'b1;
        pick_oh[idx]  = 1'b1;
        pick_idx      = IDX_W'(idx);
      end
    end
    any_req = found;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (pick_idx == IDX_W'(NUM_CH - 1)) ptr_d = '0;
      else                                ptr_d = pick_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  // R5: pointer only moves on a grant at this level
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));

  a_r5_adv_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> any_req);

endmodule

// File: rtl/dma_prio_select.sv
module dma_prio_select #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] lvl_any,
  output logic               sel_valid,
  output logic [LVL_W-1:0]   sel_level
);

  // later (higher) levels overwrite lower ones
  always_comb begin
    sel_valid = 1'b0;
    sel_level = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_any[l]) begin
        sel_valid = 1'b1;
        sel_level = LVL_W'(l);
      end
    end
  end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 2,
  localparam int NUM_LVL = 1 << PRIO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_enable,
  input  logic [NUM_CH-1:0]        ch_mode,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  input  logic [NUM_CH-1:0]        periph_req,
  input  logic                     burst_done,
  input  logic                     burst_abort,
  output logic [NUM_CH-1:0]        grant,
  output logic                     grant_valid
);

  logic [NUM_CH-1:0]  req_all;
  logic [NUM_CH-1:0]  lvl_req  [NUM_LVL];
  logic [NUM_CH-1:0]  lvl_pick [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_any;
  logic [NUM_LVL-1:0] lvl_adv;
  logic               sel_valid;
  logic [PRIO_W-1:0]  sel_level;
  logic [NUM_CH-1:0]  winner_oh;
  logic               issue;
  logic               release_g;
  logic [NUM_CH-1:0]  grant_q, grant_d;
  logic               valid_q, valid_d;

  dma_req_gen #(.NUM_CH(NUM_CH)) u_req (
    .ch_enable (ch_enable),
    .ch_mode   (ch_mode),
    .periph_req(periph_req),
    .req       (req_all)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
      assign lvl_req[l][c] = req_all[c] &
                             (ch_prio[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign lvl_adv[l] = issue && (sel_level == PRIO_W'(l));
    dma_level_rr #(.NUM_CH(NUM_CH)) u_rr (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (lvl_req[l]),
      .adv    (lvl_adv[l]),
      .any_req(lvl_any[l]),
      .pick_oh(lvl_pick[l])
    );
  end

  dma_prio_select #(.NUM_LVL(NUM_LVL)) u_sel (
    .lvl_any  (lvl_any),
    .sel_valid(sel_valid),
    .sel_level(sel_level)
  );

  assign winner_oh = lvl_pick[sel_level];
  assign issue     = !valid_q && sel_valid;
  assign release_g = valid_q && (burst_done || burst_abort);

  always_comb begin
    valid_d = valid_q;
    grant_d = grant_q;
    if (issue) begin
      valid_d = 1'b1;
      grant_d = winner_oh;
    end else if (release_g) begin
      valid_d = 1'b0;
      grant_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      grant_q <= '0;
    end else if (issue || release_g) begin
      valid_q <= valid_d;
      grant_q <= grant_d;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = valid_q;

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant == '0);

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $countones(grant) == 1);

  a_r6_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (req_all != '0)) |=>
      (grant_valid && ((grant & $past(req_all)) != '0)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !burst_done && !burst_abort) |=>
      (grant_valid && $stable(grant)));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && (burst_done || burst_abort)) |=> !grant_valid);

  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (req_all == '0)) |=> !grant_valid);

endmodule

// File: tb/dma_chan_arbiter_bench.sv
`timescale 1ns/1ps
module dma_chan_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  en, mode, periph;
  logic [15:0] prio;
  logic        done, abort;
  logic [7:0]  grant;
  logic        grant_valid;

  int n_run  = 0;
  int n_fail = 0;

  int       mptr [4];
  bit       mvalid;
  logic [7:0] mgrant;

  always #2 clk = ~clk;

  dma_chan_arbiter u_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .ch_enable(en), .ch_mode(mode),
    .ch_prio(prio), .periph_req(periph), .burst_done(done),
    .burst_abort(abort), .grant(grant), .grant_valid(grant_valid)
  );

  function automatic int prio_of(int c);
    return int'(prio[2*c +: 2]);
  endfunction

  function automatic bit wants(int c);
    return en[c] && (!mode[c] || periph[c]);
  endfunction

  function automatic int exp_winner();
    for (int l = 3; l >= 0; l--)
      for (int off = 0; off < 8; off++) begin
        int c;
        c = (mptr[l] + off) % 8;
        if (wants(c) && prio_of(c) == l) return c;
      end
    return -1;
  endfunction

  task automatic model_update();
    if (!mvalid) begin
      int w;
      w = exp_winner();
      if (w >= 0) begin
        mvalid = 1'b1;
        mgrant = 8'b1 << w;
        mptr[prio_of(w)] = (w + 1) % 8;
      end
    end else if (done || abort) begin
      mvalid = 1'b0;
      mgrant = '0;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = '0; mode = '0; periph = '0; prio = '0; done = 0; abort = 0;
    for (int l = 0; l < 4; l++) mptr[l] = 0;
    mvalid = 0; mgrant = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic end_burst(bit use_abort);
    @(negedge clk);
    done = !use_abort; abort = use_abort;
    tick();
    @(negedge clk);
    done = 0; abort = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    do_reset();
    // R9 reset state
    check("R9 grant after reset", grant, 0);
    check("R9 valid after reset", grant_valid, 0);

    // R1 memory-to-memory ignores periph line
    en[2] = 1; mode[2] = 0; periph[2] = 0;
    tick();
    check("R1 mem2mem grant", {grant_valid, grant}, {1'b1, 8'h04});

    // R10 with no requests, done does nothing
    do_reset();
    @(negedge clk); done = 1; abort = 1;
    tick();
    check("R10 pulse while idle", {grant_valid, grant}, 0);
    @(negedge clk); done = 0; abort = 0;

    // R2 peripheral-linked channel waits for its line
    en[3] = 1; mode[3] = 1; periph[3] = 0;
    tick();
    check("R2 no periph request", grant_valid, 0);
    @(negedge clk); periph[3] = 1;
    tick();
    check("R2 periph request", {grant_valid, grant}, {1'b1, 8'h08});

    // R3 disabled channel never wins
    do_reset();
    en[5] = 0; mode[5] = 0; periph[5] = 1;
    tick(); tick();
    check("R3 disabled channel", {grant_valid, grant}, 0);

    // R4 higher level wins
    do_reset();
    en = 8'h42; prio[2*1 +: 2] = 2'd1; prio[2*6 +: 2] = 2'd3;
    tick();
    check("R4 level 3 beats level 1", grant, 8'h40);

    // R5 rotation in one level: 0,4,7,0
    do_reset();
    en = 8'h91;
    prio[0 +: 2] = 2'd2; prio[8 +: 2] = 2'd2; prio[14 +: 2] = 2'd2;
    tick();
    check("R5 first pick", grant, 8'h01);
    end_burst(0);
    tick();
    check("R5 second pick", grant, 8'h10);
    end_burst(1);
    tick();
    check("R5 third pick", grant, 8'h80);
    end_burst(0);
    tick();
    check("R5 wrap pick", grant, 8'h01);

    // R7 non-preemptive hold, R8 release then re-arbitrate
    do_reset();
    en = 8'h01;
    tick();
    check("R7 low channel granted", grant, 8'h01);
    @(negedge clk); en = 8'h03; prio[2 +: 2] = 2'd3;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R7 held despite higher request", {grant_valid, grant}, {1'b1, 8'h01});
    end
    end_burst(0);
    check("R8 done clears grant", {grant_valid, grant}, 0);
    tick();
    check("R8 re-arbitration", grant, 8'h02);
    end_burst(1);
    check("R8 abort clears grant", grant_valid, 0);

    // Random phase against model
    do_reset();
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if ($urandom % 16 == 0) begin
        en = 8'($urandom); mode = 8'($urandom); prio = 16'($urandom);
      end
      periph = 8'($urandom);
      done  = ($urandom % 3 == 0);
      abort = ($urandom % 9 == 0);
      tick();
      check("R4 R5 random grant", grant, mgrant);
      check("R7 R8 random valid", grant_valid, mvalid);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule